// File: doc/BRIEF.md
# Multi-Core Hardware Semaphore Bank

This block holds a bank of hardware mutexes that several processor cores share to arbitrate access to common resources. Each semaphore is one 32-bit word in a small register space. A core claims a semaphore by writing a word with the lock flag set and its own identifier in the owner field. It then reads the word back. The claim succeeded only if the readback equals the value it wrote. The owner frees the semaphore by writing its identifier with the lock flag clear.

The bank has a parameterised number of requester ports. Each port has its own write channel and read channel. Writes that reach the same semaphore in the same cycle go through a fixed-priority choice. Reads return the semaphore state through a registered data path with a latency of one cycle.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore is unlocked with a zero owner, and every `rd_data` output is zero.
- R2: A write with bit 31 set to an unlocked semaphore locks it and stores the owner field, bits [15:8], of the written word. A later read returns bit 31 set, the owner in bits [15:8] and zero elsewhere. An owner value of 1 therefore reads as 32'h8000_0100.
- R3: A write with bit 31 set to a semaphore that is already locked changes nothing. A read shows the identifier of the current holder.
- R4: A write with bit 31 clear whose bits [15:8] equal the stored owner unlocks the semaphore and clears its owner to zero. A read of that semaphore then returns zero.
- R5: A write with bit 31 clear whose bits [15:8] differ from the stored owner is ignored, and so is such a write to an unlocked semaphore.
- R6: When several ports write the same semaphore in the same cycle, only the write from the lowest-numbered port is applied.
- R7: The word index is address bits [7:2], and address bits [1:0] are ignored. Semaphore i is at byte address 4*i. A write to index 32 or above is ignored, and a read from such an index returns zero.
- R8: A read issued with `rd_en` in one cycle shows its data on `rd_data` just after the next rising edge. The data reflects the state before any write applied at that same edge. `rd_data` holds its value while `rd_en` is low. Bits of `rd_data` other than 31 and [15:8] are always zero, whatever the written word carried there.
- R9: A write changes only the semaphore it addresses. A cycle with no write to a semaphore leaves that semaphore unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | NUM_PORTS | Per-port write strobe |
| wr_addr | input | NUM_PORTS x ADDR_W | Per-port write byte address |
| wr_data | input | NUM_PORTS x 32 | Per-port write word (bit 31 lock flag, bits [15:8] owner) |
| rd_en | input | NUM_PORTS | Per-port read strobe |
| rd_addr | input | NUM_PORTS x ADDR_W | Per-port read byte address |
| rd_data | output | NUM_PORTS x 32 | Per-port registered read word |

## Verification
A write presented in a cycle updates the semaphore at the next rising edge. A read presented in the same cycle captures the state from before that edge, and its result shows on `rd_data` just after the edge. The readback of a claim is therefore first due two cycles after the write is presented. The bench drives inputs on the falling edge and samples `rd_data` one nanosecond after every rising edge. A reference model computes the expected value of every port's read word in the cycle the read is issued, before that cycle's writes are applied, which matches the design's order. The directed cases also compare the read words against fixed constants for collisions, foreign releases, out-of-range addresses and reads issued in the same cycle as a write.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int WORD_W    = 32;
    localparam int LOCK_POS  = 31;
    localparam int OWNER_LSB = 8;
    localparam int OWNER_W   = 8;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [OWNER_W-1:0] owner_t;

    // Stored state of one semaphore.
    typedef struct packed {
        logic   locked;
        owner_t owner;
    } sem_state_t;

    // Write request that won arbitration for one semaphore.
    typedef struct packed {
        logic   valid;
        logic   claim;
        owner_t id;
    } sem_req_t;

    // Register image of a semaphore as seen on a read.
    function automatic word_t sem_word(input sem_state_t s);
        word_t w;
        w = '0;
        w[LOCK_POS] = s.locked;
        w[OWNER_LSB +: OWNER_W] = s.owner;
        return w;
    endfunction

    // Bits that may be non-zero in a read word.
    function automatic word_t live_mask();
        word_t m;
        m = '0;
        m[LOCK_POS] = 1'b1;
        m[OWNER_LSB +: OWNER_W] = '1;
        return m;
    endfunction

endpackage

// File: rtl/sem_arbiter.sv
module sem_arbiter
    import sem_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 8,
    parameter int SEM_IDX   = 0
) (
    input  logic [NUM_PORTS-1:0]             wr_en,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] wr_addr,
    input  logic [NUM_PORTS-1:0][WORD_W-1:0] wr_data,
    output sem_req_t                         req,
    output logic [NUM_PORTS-1:0]             grant
);

    localparam int IDX_W = ADDR_W - 2;

    logic [NUM_PORTS-1:0] hit;
    logic                 unused_bits;

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            hit[p] = wr_en[p] && (32'(wr_addr[p][ADDR_W-1 -: IDX_W]) == SEM_IDX);
        end
    end

    // Scan from the highest port down so the lowest hitting port is kept.
    always_comb begin
        req   = '0;
        grant = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (hit[p]) begin
                grant     = '0;
                grant[p]  = 1'b1;
                req.valid = 1'b1;
                req.claim = wr_data[p][LOCK_POS];
                req.id    = wr_data[p][OWNER_LSB +: OWNER_W];
            end
        end
    end

    assign unused_bits = ^{wr_addr, wr_data};

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sem_req_t   req,
    output sem_state_t state
);

    sem_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (req.valid) begin
            if (req.claim) begin
                if (!state_q.locked) begin
                    state_d.locked = 1'b1;
                    state_d.owner  = req.id;
                end
            end else if (state_q.locked && (req.id == state_q.owner)) begin
                state_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign state = state_q;

    a_r1_free_has_no_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.locked |-> (state_q.owner == '0));

    a_r2_claim_free_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (req.valid && req.claim && !state_q.locked)
        |=> (state_q.locked && (state_q.owner == $past(req.id))));

    a_r3_claim_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (req.valid && req.claim && state_q.locked)
        |=> (state_q.locked && $stable(state_q.owner)));

    a_r4_owner_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (req.valid && !req.claim && state_q.locked && (req.id == state_q.owner))
        |=> (state_q == '0));

    a_r5_foreign_release_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req.valid && !req.claim && (req.id != state_q.owner))
        |=> $stable(state_q));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !req.valid |=> $stable(state_q));

endmodule

// File: rtl/sem_read_port.sv
module sem_read_port
    import sem_pkg::*;
#(
    parameter int NUM_SEM = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  sem_state_t [NUM_SEM-1:0] states,
    output word_t                    rd_data
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    word_t            rd_d, rd_q;
    logic             unused_low;

    assign idx        = rd_addr[ADDR_W-1 -: IDX_W];
    assign unused_low = ^rd_addr[1:0];

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = '0;
            for (int s = 0; s < NUM_SEM; s++) begin
                if (32'(idx) == s) rd_d = sem_word(states[s]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    a_r7_out_of_range_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (32'(idx) >= NUM_SEM)) |=> (rd_data == '0));

    a_r8_holds_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    a_r8_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & ~live_mask()) == '0));

endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int NUM_SEM   = 32,
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             wr_en,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] wr_addr,
    input  logic [NUM_PORTS-1:0][WORD_W-1:0] wr_data,
    input  logic [NUM_PORTS-1:0]             rd_en,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] rd_addr,
    output logic [NUM_PORTS-1:0][WORD_W-1:0] rd_data
);

    localparam int IDX_W = ADDR_W - 2;

    sem_state_t [NUM_SEM-1:0]                states;
    sem_req_t   [NUM_SEM-1:0]                reqs;
    logic       [NUM_SEM-1:0][NUM_PORTS-1:0] grants;

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
        sem_arbiter #(
            .NUM_PORTS (NUM_PORTS),
            .ADDR_W    (ADDR_W),
            .SEM_IDX   (s)
        ) u_arb (
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .req     (reqs[s]),
            .grant   (grants[s])
        );

        sem_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (reqs[s]),
            .state (states[s])
        );

        a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grants[s]));

        a_r6_port0_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[0] && (32'(wr_addr[0][ADDR_W-1 -: IDX_W]) == s)) |-> grants[s][0]);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        sem_read_port #(
            .NUM_SEM (NUM_SEM),
            .ADDR_W  (ADDR_W)
        ) u_rd (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (rd_en[p]),
            .rd_addr (rd_addr[p]),
            .states  (states),
            .rd_data (rd_data[p])
        );
    end

endmodule

// File: tb/sem_bank_bench.sv
`timescale 1ns/1ps
module sem_bank_bench;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       wr_en = '0;
    logic [1:0][7:0]  wr_addr = '0;
    logic [1:0][31:0] wr_data = '0;
    logic [1:0]       rd_en = '0;
    logic [1:0][7:0]  rd_addr = '0;
    logic [1:0][31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_lock;
    logic [7:0]  m_own [32];
    logic [1:0][31:0] exp_rd;

    always #2 clk = ~clk;

    sem_bank u_sem_bank (
        .clk (clk), .rst_n (rst_n),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data)
    );

    function automatic logic [31:0] model_word(input logic [5:0] idx);
        if (idx >= 6'd32) return 32'h0;
        if (!m_lock[idx[4:0]]) return 32'h0;
        return 32'h8000_0000 | {16'h0, m_own[idx[4:0]], 8'h00};
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        logic [5:0] idx = a[7:2];
        if (idx < 6'd32) begin
            if (d[31] && !m_lock[idx[4:0]]) begin
                m_lock[idx[4:0]] = 1'b1;
                m_own[idx[4:0]]  = d[15:8];
            end else if (!d[31] && m_lock[idx[4:0]] && m_own[idx[4:0]] == d[15:8]) begin
                m_lock[idx[4:0]] = 1'b0;
                m_own[idx[4:0]]  = 8'h0;
            end
        end
    endtask

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // One clock cycle: drive on the falling edge, check both read ports after the rising edge.
    task automatic cyc(input logic [1:0] we, input logic [1:0][7:0] wa, input logic [1:0][31:0] wd,
                       input logic [1:0] re, input logic [1:0][7:0] ra, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        for (int p = 0; p < 2; p++) if (re[p]) exp_rd[p] = model_word(ra[p][7:2]);
        if (we[0]) model_write(wa[0], wd[0]);
        if (we[1] && !(we[0] && wa[0][7:2] == wa[1][7:2])) model_write(wa[1], wd[1]);
        @(posedge clk);
        #1;
        for (int p = 0; p < 2; p++) check(rd_data[p], exp_rd[p], tag);
    endtask

    task automatic wr1(input int p, input logic [7:0] a, input logic [31:0] d, input string tag);
        logic [1:0] we = '0;
        logic [1:0][7:0] wa = '0;
        logic [1:0][31:0] wd = '0;
        we[p] = 1'b1; wa[p] = a; wd[p] = d;
        cyc(we, wa, wd, 2'b00, '0, tag);
    endtask

    task automatic rd1(input int p, input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [1:0] re = '0;
        logic [1:0][7:0] ra = '0;
        re[p] = 1'b1; ra[p] = a;
        cyc(2'b00, '0, '0, re, ra, tag);
        check(rd_data[p], exp, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [1:0] we;
        logic [1:0] re;
        logic [1:0][7:0] wa;
        logic [1:0][7:0] ra;
        logic [1:0][31:0] wd;
        void'($urandom(32'd20240611));
        m_lock = '0;
        for (int i = 0; i < 32; i++) m_own[i] = 8'h0;
        exp_rd = '0;
        repeat (3) @(posedge clk);
        #1;
        check(rd_data[0], 32'h0, "R1");
        check(rd_data[1], 32'h0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) rd1(i % 2, 8'(i * 4), 32'h0, "R1");

        // R2 claim of a free semaphore, readback on the other port
        wr1(0, 8'd20, 32'h8000_0100, "R2");
        rd1(1, 8'd20, 32'h8000_0100, "R2");
        // R3 second claimant loses
        wr1(1, 8'd20, 32'h8000_0200, "R3");
        rd1(1, 8'd20, 32'h8000_0100, "R3");
        // R5 foreign release ignored
        wr1(1, 8'd20, 32'h0000_0200, "R5");
        rd1(0, 8'd20, 32'h8000_0100, "R5");
        wr1(0, 8'd24, 32'h0000_0400, "R5");
        rd1(0, 8'd24, 32'h0, "R5");
        // R4 owner release
        wr1(0, 8'd20, 32'h0000_0100, "R4");
        rd1(1, 8'd20, 32'h0, "R4");

        // R6 same-cycle collision on semaphore 7
        we = 2'b11; wa[0] = 8'd28; wa[1] = 8'd28;
        wd[0] = 32'h8000_0300; wd[1] = 32'h8000_0200;
        cyc(we, wa, wd, 2'b00, '0, "R6");
        rd1(1, 8'd28, 32'h8000_0300, "R6");
        // R6 collision where port 0 releases, port 1 claims: release wins, claim dropped
        wd[0] = 32'h0000_0300; wd[1] = 32'h8000_0200;
        cyc(we, wa, wd, 2'b00, '0, "R6");
        rd1(0, 8'd28, 32'h0, "R6");

        // R7 out-of-range and unaligned addresses
        wr1(0, 8'd128, 32'h8000_0500, "R7");
        rd1(0, 8'd128, 32'h0, "R7");
        rd1(1, 8'd252, 32'h0, "R7");
        rd1(1, 8'd0, 32'h0, "R7");
        wr1(1, 8'd39, 32'h8000_0600, "R7");
        rd1(0, 8'd36, 32'h8000_0600, "R7");
        rd1(1, 8'd38, 32'h8000_0600, "R7");

        // R8 spare bits dropped, read in the write cycle sees old state, hold when idle
        wr1(0, 8'd44, 32'hFFFF_07FF, "R8");
        rd1(0, 8'd44, 32'h8000_0700, "R8");
        we = 2'b01; wa[0] = 8'd48; wd[0] = 32'h8000_0900;
        re = 2'b10; ra[1] = 8'd48;
        cyc(we, wa, wd, re, ra, "R8");
        check(rd_data[1], 32'h0, "R8");
        cyc(2'b00, '0, '0, 2'b00, '0, "R8");
        check(rd_data[1], 32'h0, "R8");
        rd1(1, 8'd48, 32'h8000_0900, "R8");
        // R9 neighbours untouched
        rd1(0, 8'd44, 32'h8000_0700, "R9");
        rd1(0, 8'd52, 32'h0, "R9");

        // Constrained random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            for (int p = 0; p < 2; p++) begin
                we[p] = 1'($urandom_range(0, 1));
                re[p] = 1'($urandom_range(0, 1));
                wa[p] = {6'($urandom_range(0, 39)), 2'($urandom_range(0, 3))};
                ra[p] = {6'($urandom_range(0, 39)), 2'($urandom_range(0, 3))};
                wd[p] = $urandom;
                wd[p][31] = 1'($urandom_range(0, 1));
                wd[p][15:8] = 8'($urandom_range(1, 3));
            end
            cyc(we, wa, wd, re, ra, "R9");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule